// File: doc/BRIEF.md
# Raster-Line Interrupt Field Sequencer

This block follows the beam through a frame of `LINES` scan lines (262 by default, lines 50 to 249 visible). It compares the line it is on with a programmable 9-bit line number. When the counter steps onto that line, the block sets a sticky raster status bit. If the mask allows it, the block raises an interrupt request. A line-rate enable input advances the counter, so one frame takes 262 enables, which is one sixtieth of a second at the usual line rate.

The block also times how long a stimulus field stays on screen by counting raster matches. Software arms the sequencer by setting the mask bit, which loads a sweep counter with `SWEEP_LOAD` (90 by default, about 1.5 s). Each match while armed counts down. On the match that reaches zero, in the same clock, the block does three things:
- It clears its own mask bit.
- It pulses `timer_start` for an external reaction timer.
- It puts the second field's code into the upper nibble of the display-memory select register. The lower nibble of that register is kept.

The reset compare line is 250, which lies outside the picture, so the field swap never tears the image.

Top module: `raster_field_seq`

## Requirements
- R1: After reset `line_num` is 0. Each clock with `line_en` high advances it by one, and from `LINES-1` (261) it wraps to 0.
- R2: While `line_en` is low, `line_num` holds its value.
- R3: The compare line is 9 bits.
  - Its low 8 bits are at address 0.
  - Its bit 8 is bit 7 of address 1.
  - When the counter steps onto the compare line, status bit 0 (address 2) reads 1 from that same clock on.
- R4: `irq` is high exactly when status bit 0 and mask bit 0 (address 3) are both 1. Status bit 7 reads 1 under the same condition.
- R5: A write to address 2 with bit 0 set clears status bit 0. A match in the same clock wins over the clear.
- R6: A line is counted as a match once, when it is entered. Holding `line_en` low on the compare line adds no match.
- R7: A write of 1 to mask bit 0 reloads the sweep counter with `SWEEP_LOAD`. Each match while mask bit 0 is 1 decrements the counter.
- R8: On the match that takes the sweep counter to zero, and not before, all of the following happen in the same clock:
  - Mask bit 0 becomes 0.
  - `timer_start` is high for exactly one clock.
  - The register at address 4 takes `FIELD2_SEL` (9) in bits 7:4 and keeps bits 3:0.
  - `field_sel` shows bits 7:4 of that register.
- R9: Reset values:
  - status 0, mask 0, `irq` 0, `timer_start` 0
  - address 4 holds 0x15
  - compare low byte is 0xFA and bit 8 is 0, so the compare line is 250

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_en | input | 1 | Line-rate advance strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address (0 cmp low, 1 ctrl, 2 status, 3 mask, 4 memory select) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| irq | output | 1 | Raster interrupt request |
| timer_start | output | 1 | One-clock start pulse for the reaction timer |
| field_sel | output | 4 | Upper nibble of the memory-select register |
| line_num | output | 9 | Current scan line |

## Verification
The bench builds the block with its defaults: 262 lines, 90 sweeps and field code 9. Holding the line enable high brings a full 90-frame armed run and the following wrap into reach in about 25k clocks. A pause on line 250 shows that a stalled match line is counted once. Moving the compare line to 261 exercises the ninth compare bit, with the mask already cleared by the sequencer.

// File: rtl/raster_seq_pkg.sv
package raster_seq_pkg;
    typedef enum logic [2:0] {
        RS_CMP_LO = 3'd0,
        RS_CTRL   = 3'd1,
        RS_STAT   = 3'd2,
        RS_MASK   = 3'd3,
        RS_MEMSEL = 3'd4
    } rs_addr_e;
endpackage

// File: rtl/raster_line_ctr.sv
module raster_line_ctr #(
    parameter int LINES = 262,
    parameter int LW    = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_en,
    output logic [LW-1:0] line_q,
    output logic [LW-1:0] line_nxt
);
    localparam logic [LW-1:0] LAST = LW'(LINES - 1);

    typedef struct packed {
        logic [LW-1:0] line;
    } lc_t;

    lc_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        line_nxt = (st_q.line == LAST) ? '0 : st_q.line + 1'b1;
        if (line_en) st_d.line = line_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign line_q = st_q.line;

    assert_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (line_en && line_q == LAST) |=> (line_q == '0));
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !line_en |=> $stable(line_q));
endmodule

// File: rtl/raster_cmp.sv
module raster_cmp #(
    parameter int LW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_en,
    input  logic [LW-1:0] line_nxt,
    input  logic [LW-1:0] cmp_line,
    input  logic          clr,
    output logic          match,
    output logic          stat_q
);
    typedef struct packed {
        logic stat;
    } cmp_t;

    cmp_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        match = line_en && (line_nxt == cmp_line);
        if (clr)   st_d.stat = 1'b0;
        if (match) st_d.stat = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat_q = st_q.stat;

    assert_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> stat_q);
    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !match) |=> !stat_q);
    assert_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> !match);
endmodule

// File: rtl/field_seq.sv
module field_seq #(
    parameter int         CW         = 8,
    parameter int         SWEEP_LOAD = 90,
    parameter logic [3:0] FIELD2_SEL = 4'h9,
    parameter logic [7:0] MEM_RST    = 8'h15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       match,
    input  logic       mask_we,
    input  logic       mask_bit,
    input  logic       mem_we,
    input  logic [7:0] mem_wdata,
    output logic       mask_q,
    output logic [7:0] mem_q,
    output logic       start_q
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          mask;
        logic [7:0]    mem;
        logic          start;
    } fs_t;

    fs_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;
        if (match && st_q.mask && st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
            if (st_q.cnt == CW'(1)) begin
                st_d.mask  = 1'b0;
                st_d.start = 1'b1;
                st_d.mem   = {FIELD2_SEL, st_q.mem[3:0]};
            end
        end
        if (mem_we) st_d.mem = mem_wdata;
        if (mask_we) begin
            st_d.mask = mask_bit;
            if (mask_bit) st_d.cnt = CW'(SWEEP_LOAD);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt   <= CW'(SWEEP_LOAD);
            st_q.mask  <= 1'b0;
            st_q.mem   <= MEM_RST;
            st_q.start <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_q  = st_q.mask;
    assign mem_q   = st_q.mem;
    assign start_q = st_q.start;

    assert_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (match && st_q.mask && !mask_we && st_q.cnt > CW'(1)) |=> (st_q.cnt == $past(st_q.cnt) - 1'b1));
    assert_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |=> !start_q);
    assert_maskoff_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_q && !$past(mask_we)) |-> !mask_q);
    assert_keep_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_q && !$past(mem_we)) |-> (mem_q == {FIELD2_SEL, $past(mem_q[3:0])}));
endmodule

// File: rtl/raster_field_seq.sv
module raster_field_seq
    import raster_seq_pkg::*;
#(
    parameter int         LINES      = 262,
    parameter int         SWEEP_LOAD = 90,
    parameter logic [3:0] FIELD2_SEL = 4'h9,
    localparam int        LW         = $clog2(LINES),
    localparam int        CW         = $clog2(SWEEP_LOAD + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_en,
    input  logic          wr_en,
    input  logic [2:0]    addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata,
    output logic          irq,
    output logic          timer_start,
    output logic [3:0]    field_sel,
    output logic [LW-1:0] line_num
);
    typedef struct packed {
        logic [7:0] lo;
        logic       hi;
    } cmp_reg_t;

    cmp_reg_t cr_d, cr_q;
    logic [LW-1:0] line_nxt, cmp_line;
    logic          match, stat_q, mask_q, stat_clr, mask_we, mem_we;
    logic [7:0]    mem_q;

    always_comb begin
        cr_d     = cr_q;
        stat_clr = 1'b0;
        mask_we  = 1'b0;
        mem_we   = 1'b0;
        if (wr_en) begin
            case (addr)
                RS_CMP_LO: cr_d.lo  = wdata;
                RS_CTRL:   cr_d.hi  = wdata[7];
                RS_STAT:   stat_clr = wdata[0];
                RS_MASK:   mask_we  = 1'b1;
                RS_MEMSEL: mem_we   = 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cr_q <= '{lo: 8'hFA, hi: 1'b0};
        else        cr_q <= cr_d;
    end

    assign cmp_line = LW'({cr_q.hi, cr_q.lo});

    raster_line_ctr #(.LINES(LINES), .LW(LW)) u_line (
        .clk(clk), .rst_n(rst_n), .line_en(line_en),
        .line_q(line_num), .line_nxt(line_nxt)
    );

    raster_cmp #(.LW(LW)) u_cmp (
        .clk(clk), .rst_n(rst_n), .line_en(line_en), .line_nxt(line_nxt),
        .cmp_line(cmp_line), .clr(stat_clr), .match(match), .stat_q(stat_q)
    );

    field_seq #(.CW(CW), .SWEEP_LOAD(SWEEP_LOAD), .FIELD2_SEL(FIELD2_SEL), .MEM_RST(8'h15)) u_seq (
        .clk(clk), .rst_n(rst_n), .match(match), .mask_we(mask_we),
        .mask_bit(wdata[0]), .mem_we(mem_we), .mem_wdata(wdata),
        .mask_q(mask_q), .mem_q(mem_q), .start_q(timer_start)
    );

    assign irq       = stat_q & mask_q;
    assign field_sel = mem_q[7:4];

    always_comb begin
        case (addr)
            RS_CMP_LO: rdata = cr_q.lo;
            RS_CTRL:   rdata = {cr_q.hi, 7'b0};
            RS_STAT:   rdata = {stat_q & mask_q, 6'b0, stat_q};
            RS_MASK:   rdata = {7'b0, mask_q};
            RS_MEMSEL: rdata = mem_q;
            default:   rdata = 8'h00;
        endcase
    end

    assert_irq_needs_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(match) || $past(mask_we)));
    assert_start_on_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
        timer_start |-> (line_num == cmp_line || $past(wr_en)));
endmodule

// File: tb/raster_field_seq_tb.sv
module raster_field_seq_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq, timer_start;
    logic [3:0] field_sel;
    logic [8:0] line_num;

    int n_chk = 0;
    int n_bad = 0;

    typedef struct {
        int sweep;
        int line;
        int field;
    } exp_t;
    exp_t sb_q[$];

    int  ml = 0;
    int  cmp_model = 250;
    int  model_sweeps = 0;
    bit  model_armed = 0;
    bit  line_mon_on = 0;

    always #2 clk = ~clk;

    raster_field_seq u_dut (
        .clk(clk), .rst_n(rst_n), .line_en(line_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq),
        .timer_start(timer_start), .field_sel(field_sel), .line_num(line_num)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // driver: arm the sequencer and push the expected start event
    task automatic arm();
        exp_t e;
        model_armed  = 1;
        model_sweeps = 0;
        e.sweep = 90;
        e.line  = 250;
        e.field = 9;
        sb_q.push_back(e);
        wr(3'd3, 8'h01);
    endtask

    task automatic wait_line(input int n);
        while (line_num != 9'(n)) @(negedge clk);
    endtask

    // reference line and sweep model (R1, R6, R7)
    always @(posedge clk) begin
        int nl;
        if (!rst_n) begin
            ml = 0;
        end else if (line_en) begin
            nl = (ml == 261) ? 0 : ml + 1;
            if (model_armed && nl == cmp_model) begin
                model_sweeps++;
                if (model_sweeps == 90) model_armed = 0;
            end
            ml = nl;
        end
    end

    // monitor: line tracking and scoreboard pop on timer start
    always @(negedge clk) begin
        if (rst_n && line_mon_on) chk("R1 line", int'(line_num), ml);
        if (rst_n && timer_start) begin
            if (sb_q.size() == 0) begin
                chk("R8 unexpected start", 1, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                chk("R7 sweep at start", model_sweeps, e.sweep);
                chk("R8 start line", int'(line_num), e.line);
                chk("R8 field at start", int'(field_sel), e.field);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        line_mon_on = 1;
        // R9 reset values
        chk("R9 line", int'(line_num), 0);
        rd(3'd2, d); chk("R9 status", d, 8'h00);
        rd(3'd3, d); chk("R9 mask", d, 8'h00);
        rd(3'd4, d); chk("R9 memsel", d, 8'h15);
        rd(3'd0, d); chk("R9 cmp low", d, 8'hFA);
        rd(3'd1, d); chk("R9 ctrl", d, 8'h00);
        chk("R9 irq", irq, 0);
        chk("R9 start", timer_start, 0);
        chk("R9 field", field_sel, 1);
        // R2 hold without enable
        repeat (4) @(negedge clk);
        chk("R2 hold", int'(line_num), 0);

        arm();
        line_en = 1'b1;
        wait_line(250);
        rd(3'd2, d); chk("R3 status set", d[0], 1);
        chk("R4 status bit7", d[7], 1);
        chk("R4 irq", irq, 1);
        // stall on the match line: R6 and R2
        line_en = 1'b0;
        repeat (4) @(negedge clk);
        chk("R2 hold at 250", int'(line_num), 250);
        wr(3'd2, 8'h81);
        rd(3'd2, d); chk("R5 status cleared", d, 8'h00);
        chk("R5 irq low", irq, 0);
        line_en = 1'b1;

        while (model_sweeps < 90) @(negedge clk);
        @(negedge clk);
        rd(3'd3, d); chk("R8 mask cleared", d, 8'h00);
        rd(3'd4, d); chk("R8 memsel", d, 8'h95);
        chk("R8 field_sel", field_sel, 9);
        chk("R8 irq off", irq, 0);
        chk("R8 scoreboard drained", sb_q.size(), 0);

        // ninth compare bit: line 261
        wait_line(255);
        wr(3'd0, 8'h05);
        wr(3'd1, 8'h80);
        wr(3'd2, 8'h01);
        wait_line(2);
        wr(3'd2, 8'h01);
        wait_line(100);
        rd(3'd2, d); chk("R3 line 5 not matched", d[0], 0);
        wait_line(261);
        rd(3'd2, d); chk("R3 ninth bit match", d[0], 1);
        chk("R4 bit7 masked", d[7], 0);
        chk("R4 irq masked", irq, 0);
        @(negedge clk);
        chk("R1 wrap", int'(line_num), 0);
        chk("R8 no second start", sb_q.size(), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule